// File: doc/BRIEF.md
# UART Automatic RTS/CTS Flow Control

This block throttles a UART without software help. It watches the CTS modem input to pause the serial transmitter, and it drives the RTS modem output from the receive FIFO fill count. The goal is to keep the remote end from overrunning the local receive FIFO.

The transmit side is gated only at character boundaries. A CTS stop request holds the transmitter only after the stop bit of the character in flight has gone out, or right away if the transmitter is idle.

The receive side has hysteresis. RTS goes off (pin high) once the fill count reaches the trigger level one step above the programmed one. It comes back on (pin low) only when the FIFO has drained completely. Characters still arriving while RTS is off are stored by the FIFO until it is full; that storage is outside this block.

Both directions are automatic only while the auto-flow enable bit and the software RTS bit are set together. Otherwise the block passes the software RTS bit through to the pin and always permits transmission. The transmitter, the FIFOs and the baud generator sit outside and are seen only through their handshake signals.

Top module: `uart_flow_ctrl`

## Requirements
- R1: Automatic flow control is active only when `auto_en_i` and `rts_bit_i` are both 1. In every other case `tx_permit_o` is 1 one clock later, and `rts_o` equals the inverse of `rts_bit_i` with no delay (bit 1 gives pin 0).
- R2: The trigger ladder, indexed by `trig_sel_i` 0..3, is 1, depth/4, depth/2 and depth−depth/8. The depth is DEEP_DEPTH when `deep_mode_i` is 1 and SHALLOW_DEPTH when it is 0. With the defaults this gives 1,16,32,56 and 1,4,8,14.
- R3: With automatic flow active, `rts_o` becomes 1 on the clock edge at which `rx_fill_i` is at or above the ladder entry one index above `trig_sel_i`.
- R4: When `trig_sel_i` is 3 (top entry), the release level is that same top entry.
- R5: Once driven to 1, `rts_o` stays 1 for every nonzero fill value. It returns to 0 on the clock edge at which `rx_fill_i` is 0.
- R6: `cts_pin_i` passes through a two-flop synchronizer. With the transmitter idle, a change on the pin reaches `tx_permit_o` on the third rising clock edge after the pin changes, and not before.
- R7: While the transmitter is busy (`tx_idle_i` = 0), `tx_permit_o` does not change except on a clock edge where `stop_done_i` is 1. A CTS stop therefore never cuts a character short.
- R8: With CTS synchronized low and the transmitter idle or at a stop-bit strobe, `tx_permit_o` returns to 1 on the next edge.
- R9: During and after reset, `tx_permit_o` is 1 and the RTS hold state is cleared, so `rts_o` equals the inverse of `rts_bit_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cts_pin_i | input | 1 | Raw CTS pin level (1 = remote asks to stop) |
| rx_fill_i | input | CNT_W | Receive FIFO fill count |
| trig_sel_i | input | 2 | Programmed receive trigger index |
| deep_mode_i | input | 1 | 1 = deep FIFO ladder, 0 = shallow |
| auto_en_i | input | 1 | Auto-flow enable control bit |
| rts_bit_i | input | 1 | Software RTS control bit |
| stop_done_i | input | 1 | One-cycle strobe when the transmitter finishes a stop bit |
| tx_idle_i | input | 1 | 1 when the transmitter has no character in progress |
| tx_permit_o | output | 1 | 1 = transmitter may start a character |
| rts_o | output | 1 | RTS pin level (1 = off) |

## Verification
The bench builds the block with its default depths, 64 for the deep ladder and 16 for the shallow one, so CNT_W is 7. These values are small enough that every fill count from empty to full and back can be swept for each of the four trigger indices in both ladders. That sweep covers the release edge of every ladder step, including the top-level case, and the full drain back to empty. The CTS path is then driven through its synchronizer latency, busy versus idle gating, strobe timing and each combination of the enables.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

  // trigger ladder: 1, d/4, d/2, d - d/8
  function automatic int unsigned ladder_lvl(input int unsigned depth,
                                             input logic [1:0] idx);
    case (idx)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - depth / 8;
    endcase
  endfunction

  // ladder index one step up, saturating at the top
  function automatic logic [1:0] next_idx(input logic [1:0] idx);
    return (idx == 2'd3) ? 2'd3 : idx + 2'd1;
  endfunction

endpackage

// File: rtl/cts_sync.sv
module cts_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/rts_ctrl.sv
module rts_ctrl
  import uart_fc_pkg::*;
#(
  parameter int unsigned DEEP_DEPTH    = 64,
  parameter int unsigned SHALLOW_DEPTH = 16,
  parameter int unsigned CNT_W         = $clog2(DEEP_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flow_on_i,
  input  logic [CNT_W-1:0] rx_fill_i,
  input  logic [1:0]       trig_sel_i,
  input  logic             deep_mode_i,
  output logic             rts_off_o
);
  localparam logic [CNT_W-1:0] FILL_EMPTY = '0;

  logic [CNT_W-1:0] release_lvl;
  logic             off_q;
  logic [1:0]       rel_idx;

  always_comb begin
    rel_idx = next_idx(trig_sel_i);
    if (deep_mode_i) release_lvl = CNT_W'(ladder_lvl(DEEP_DEPTH, rel_idx));
    else             release_lvl = CNT_W'(ladder_lvl(SHALLOW_DEPTH, rel_idx));
  end

  // hysteresis: off at release level, on again only when drained
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       off_q <= 1'b0;
    else if (!flow_on_i)               off_q <= 1'b0;
    else if (rx_fill_i >= release_lvl) off_q <= 1'b1;
    else if (rx_fill_i == FILL_EMPTY)  off_q <= 1'b0;
  end

  assign rts_off_o = off_q;
endmodule

// File: rtl/tx_gate.sv
module tx_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flow_on_i,
  input  logic cts_stop_i,
  input  logic stop_done_i,
  input  logic tx_idle_i,
  output logic tx_permit_o
);
  logic permit_q;

  // only update at a character boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      permit_q <= 1'b1;
    else if (!flow_on_i)              permit_q <= 1'b1;
    else if (stop_done_i || tx_idle_i) permit_q <= !cts_stop_i;
  end

  assign tx_permit_o = permit_q;
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl #(
  parameter int unsigned DEEP_DEPTH    = 64,
  parameter int unsigned SHALLOW_DEPTH = 16,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned CNT_W         = $clog2(DEEP_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cts_pin_i,
  input  logic [CNT_W-1:0] rx_fill_i,
  input  logic [1:0]       trig_sel_i,
  input  logic             deep_mode_i,
  input  logic             auto_en_i,
  input  logic             rts_bit_i,
  input  logic             stop_done_i,
  input  logic             tx_idle_i,
  output logic             tx_permit_o,
  output logic             rts_o
);
  logic flow_on;
  logic cts_s;
  logic rts_off;

  assign flow_on = auto_en_i & rts_bit_i;

  cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (cts_pin_i),
    .q_o    (cts_s)
  );

  tx_gate u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flow_on_i   (flow_on),
    .cts_stop_i  (cts_s),
    .stop_done_i (stop_done_i),
    .tx_idle_i   (tx_idle_i),
    .tx_permit_o (tx_permit_o)
  );

  rts_ctrl #(
    .DEEP_DEPTH    (DEEP_DEPTH),
    .SHALLOW_DEPTH (SHALLOW_DEPTH),
    .CNT_W         (CNT_W)
  ) u_rts (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flow_on_i   (flow_on),
    .rx_fill_i   (rx_fill_i),
    .trig_sel_i  (trig_sel_i),
    .deep_mode_i (deep_mode_i),
    .rts_off_o   (rts_off)
  );

  // pin is active low: software bit 1 drives pin 0
  assign rts_o = flow_on ? rts_off : ~rts_bit_i;
endmodule

// File: rtl/uart_flow_ctrl_chk.sv
module uart_flow_ctrl_chk #(
  parameter int unsigned CNT_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cts_pin_i,
  input logic [CNT_W-1:0] rx_fill_i,
  input logic             auto_en_i,
  input logic             rts_bit_i,
  input logic             stop_done_i,
  input logic             tx_idle_i,
  input logic             tx_permit_o,
  input logic             rts_o
);
  logic fl_on;
  assign fl_on = auto_en_i & rts_bit_i;

  assert_permit_when_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_on |=> tx_permit_o);

  assert_rts_rise_nonempty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_on && $past(fl_on) && $rose(rts_o) |-> $past(rx_fill_i) != '0);

  assert_rts_fall_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_on && $past(fl_on) && $fell(rts_o) |-> $past(rx_fill_i) == '0);

  assert_hold_mid_char_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_on && !stop_done_i && !tx_idle_i |=> $stable(tx_permit_o));

  assert_stop_needs_cts_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_permit_o) |-> $past(cts_pin_i, 3));
endmodule

bind uart_flow_ctrl uart_flow_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cts_pin_i   (cts_pin_i),
  .rx_fill_i   (rx_fill_i),
  .auto_en_i   (auto_en_i),
  .rts_bit_i   (rts_bit_i),
  .stop_done_i (stop_done_i),
  .tx_idle_i   (tx_idle_i),
  .tx_permit_o (tx_permit_o),
  .rts_o       (rts_o)
);

// File: tb/sim_uart_flow_ctrl.sv
`timescale 1ns/1ps
module sim_uart_flow_ctrl;
  localparam int unsigned DEEP = 64;
  localparam int unsigned SHAL = 16;
  localparam int unsigned CW   = $clog2(DEEP + 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cts = 1'b0;
  logic [CW-1:0] fill = '0;
  logic [1:0] tsel = '0;
  logic deep = 1'b1;
  logic auto_en = 1'b0;
  logic rts_bit = 1'b0;
  logic sdone = 1'b0;
  logic idle = 1'b0;
  logic permit, rts;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_flow_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cts_pin_i(cts), .rx_fill_i(fill),
    .trig_sel_i(tsel), .deep_mode_i(deep), .auto_en_i(auto_en),
    .rts_bit_i(rts_bit), .stop_done_i(sdone), .tx_idle_i(idle),
    .tx_permit_o(permit), .rts_o(rts)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // one rising edge, then back to the falling edge for sampling/driving
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  function automatic int unsigned lvl(input int unsigned d, input int unsigned i);
    if (i == 0) return 1;
    if (i == 1) return d / 4;
    if (i == 2) return d / 2;
    return d - d / 8;
  endfunction

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(2);
    // R9 reset state
    chk("R9 permit in reset", permit, 1'b1);
    chk("R9 rts in reset", rts, 1'b1);
    rst_ni = 1'b1;
    tick(1);
    chk("R9 permit after reset", permit, 1'b1);

    // R2 R3 R4 R5 ladder sweep
    auto_en = 1'b1; rts_bit = 1'b1;
    for (int dm = 0; dm < 2; dm++) begin
      for (int s = 0; s < 4; s++) begin
        int unsigned d, rel;
        d = (dm == 1) ? DEEP : SHAL;
        rel = lvl(d, (s == 3) ? 3 : s + 1);
        deep = dm[0]; tsel = s[1:0]; fill = '0;
        tick(1);
        chk("R5 start empty", rts, 1'b0);
        for (int f = 1; f <= int'(d); f++) begin
          fill = CW'(f);
          tick(1);
          chk((s == 3) ? "R4 top level release" : "R3 R2 release level",
              rts, (f >= int'(rel)));
        end
        for (int f = int'(d) - 1; f >= 1; f--) begin
          fill = CW'(f);
          tick(1);
          chk("R5 held while draining", rts, 1'b1);
        end
        fill = '0;
        tick(1);
        chk("R5 reassert at empty", rts, 1'b0);
      end
    end

    // R7 busy transmitter
    deep = 1'b1; tsel = 2'd0; fill = '0; idle = 1'b0;
    cts = 1'b1;
    tick(6);
    chk("R7 no stop mid character", permit, 1'b1);
    sdone = 1'b1;
    tick(1);
    sdone = 1'b0;
    chk("R7 stop at stop bit", permit, 1'b0);
    cts = 1'b0;
    tick(4);
    chk("R7 hold while busy", permit, 1'b0);
    // R8 resume when idle
    idle = 1'b1;
    tick(1);
    chk("R8 resume idle", permit, 1'b1);

    // R6 synchronizer latency
    cts = 1'b1;
    tick(2);
    chk("R6 not before third edge", permit, 1'b1);
    tick(1);
    chk("R6 third edge stop", permit, 1'b0);
    cts = 1'b0;
    tick(2);
    chk("R6 release not early", permit, 1'b0);
    tick(1);
    chk("R6 release third edge", permit, 1'b1);

    // R8 resume at strobe while busy
    cts = 1'b1;
    tick(4);
    idle = 1'b0;
    cts = 1'b0;
    tick(3);
    chk("R8 busy waits", permit, 1'b0);
    sdone = 1'b1;
    tick(1);
    sdone = 1'b0;
    chk("R8 resume at strobe", permit, 1'b1);

    // R1 enables
    idle = 1'b1; cts = 1'b1;
    tick(4);
    chk("R1 stopped with flow on", permit, 1'b0);
    auto_en = 1'b0;
    tick(1);
    chk("R1 permit with auto off", permit, 1'b1);
    chk("R1 rts follows bit 1", rts, 1'b0);
    rts_bit = 1'b0;
    #1;
    chk("R1 rts follows bit 0", rts, 1'b1);
    auto_en = 1'b1;
    fill = CW'(DEEP);
    tick(2);
    chk("R1 one bit only permit", permit, 1'b1);
    chk("R1 one bit only rts", rts, 1'b1);
    rts_bit = 1'b1; auto_en = 1'b0;
    tick(2);
    chk("R1 full fifo auto off", rts, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule